// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimator

This block takes the single-bit output of an external analog sigma-delta modulator and turns it into signed 16-bit PCM words. Input bits are sampled on the system clock whenever a one-cycle oversampling enable is high. The oversampling rate is 128 times the base sample rate and output words come out at twice the base rate, so every 64 accepted bits give one word. The two supported rate sets are 1.2288 MHz in to 19.2 kHz out and 1.024 MHz in to 16 kHz out. The block does not need to know which set is in use, because it counts enables and never measures time.

Each accepted bit is mapped to +1 (bit 1) or -1 (bit 0). The value goes through a third-order cascaded integrator-comb filter with a differential delay of one and wraparound arithmetic. The comb result is scaled down by an arithmetic right shift and clamped to the 16-bit range. A synchronous clear input restarts the filter and the decimation phase without a full reset. The analog modulator, the IIR stages that follow and the gain control all sit outside this block.

Top module: `sdd_decimator`

## Requirements
- R1: After reset, and in the clock cycle after `clr` is sampled high, `pcm_out` is 0 and `pcm_vld` is 0.
- R2: `pcm_vld` is high for exactly one clock per 64 accepted enables. It is high in the second clock after the edge that samples the 64th enable.
- R3: While `os_en` is low, `bit_in` has no effect: later output words depend only on bits sampled with `os_en` high.
- R4: A bit value of 1 is integrated as +1 and a value of 0 as -1, so a run of ones moves the output positive and a run of zeros moves it negative.
- R5: A steady stream of ones gives `pcm_out` = 16'h7FFF (saturated full positive scale) once the filter has settled.
- R6: A steady stream of zeros gives `pcm_out` = 16'h8000 (full negative scale) once the filter has settled.
- R7: Each output word is floor(C / 8) clamped to [-32768, 32767], where C is the third-order integrator-comb response over the accepted ±1 samples, with pipelined integrators and a differential delay of one.
- R8: A clear restarts the phase: after `clr`, the first `pcm_vld` follows the 64th enable accepted after the clear and never an earlier one.
- R9: `pcm_out` changes only in the cycle where `pcm_vld` is high, or as a result of a clear or a reset.
- R10: Output words depend only on the sequence of accepted bits and not on the spacing of the enables, so every enable rate gives the same words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all filter state and of the phase |
| os_en | input | 1 | Oversampling enable; `bit_in` is accepted when high |
| bit_in | input | 1 | Modulator bitstream, 1 = +1, 0 = -1 |
| pcm_out | output | 16 | Signed decimated PCM word |
| pcm_vld | output | 1 | One-clock strobe marking a new `pcm_out` |

## Verification
The checker assumes that `clr` is held low during reset and that `os_en` is a clean synchronous level. It also assumes no accepted-enable count other than its own modulo-64 phase, restarted by clear, controls the strobe. The stimulus drives every input on the falling edge, so each input is steady at the sampling edge. Enable patterns run back to back, every other cycle and irregularly, with `bit_in` toggled at random while `os_en` is low. Clear is applied both at a phase boundary and in the middle of a decimation window, so the phase-restart and hold properties are exercised under the assumptions they rely on.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

   // Default geometry of the decimator
   localparam int unsigned SDD_DECIM   = 64;
   localparam int unsigned SDD_ORDER   = 3;
   localparam int unsigned SDD_OUT_W   = 16;
   // A +/-1 input needs two bits before any growth
   localparam int unsigned SDD_IN_BITS = 2;

   // Accumulator width: input bits plus order * log2(decimation)
   function automatic int unsigned acc_width(input int unsigned order,
                                             input int unsigned decim);
      return SDD_IN_BITS + order * $clog2(decim);
   endfunction

   // Right shift that maps the filter gain onto the output width
   function automatic int scale_shift(input int unsigned order,
                                      input int unsigned decim,
                                      input int unsigned out_w);
      return int'(order * $clog2(decim)) - int'(out_w - 1);
   endfunction

endpackage

// File: rtl/sdd_phase_ctr.sv
module sdd_phase_ctr #(
   parameter int unsigned DECIM = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic os_en,
   output logic dump
);
   localparam int unsigned CW = (DECIM > 2) ? $clog2(DECIM) : 1;
   localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

   logic [CW-1:0] phase_q;
   logic          wrap;

   assign wrap = os_en && (phase_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (clr) begin
         phase_q <= '0;
      end else if (os_en) begin
         phase_q <= wrap ? '0 : phase_q + 1'b1;
      end
   end

   // Registered so the comb sees the integrator after its last update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dump <= 1'b0;
      end else if (clr) begin
         dump <= 1'b0;
      end else begin
         dump <= wrap;
      end
   end

endmodule

// File: rtl/sdd_integ_chain.sv
module sdd_integ_chain #(
   parameter int unsigned ORDER = 3,
   parameter int unsigned ACC_W = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    os_en,
   input  logic                    bit_in,
   output logic signed [ACC_W-1:0] acc_o
);
   localparam logic signed [ACC_W-1:0] PLUS_ONE  = ACC_W'(1);
   localparam logic signed [ACC_W-1:0] MINUS_ONE = {ACC_W{1'b1}};

   logic signed [ACC_W-1:0] sample;
   logic signed [ACC_W-1:0] stg [ORDER];

   assign sample = bit_in ? PLUS_ONE : MINUS_ONE;

   for (genvar k = 0; k < int'(ORDER); k++) begin : g_stage
      logic signed [ACC_W-1:0] feed;
      if (k == 0) begin : g_head
         assign feed = sample;
      end else begin : g_tail
         assign feed = stg[k-1];
      end

      // Wraparound add; the comb differences cancel any overflow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[k] <= '0;
         end else if (clr) begin
            stg[k] <= '0;
         end else if (os_en) begin
            stg[k] <= stg[k] + feed;
         end
      end
   end

   assign acc_o = stg[ORDER-1];

endmodule

// File: rtl/sdd_comb_chain.sv
module sdd_comb_chain #(
   parameter int unsigned ORDER = 3,
   parameter int unsigned ACC_W = 20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    dump,
   input  logic signed [ACC_W-1:0] acc_i,
   output logic signed [ACC_W-1:0] diff_o
);
   logic signed [ACC_W-1:0] tap [ORDER+1];
   logic signed [ACC_W-1:0] dly [ORDER];

   assign tap[0] = acc_i;

   for (genvar k = 0; k < int'(ORDER); k++) begin : g_comb
      assign tap[k+1] = tap[k] - dly[k];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dly[k] <= '0;
         end else if (clr) begin
            dly[k] <= '0;
         end else if (dump) begin
            dly[k] <= tap[k];
         end
      end
   end

   assign diff_o = tap[ORDER];

endmodule

// File: rtl/sdd_scale_sat.sv
module sdd_scale_sat #(
   parameter int unsigned ACC_W    = 20,
   parameter int unsigned OUT_W    = 16,
   parameter int unsigned SHIFT    = 3,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    dump,
   input  logic signed [ACC_W-1:0] diff_i,
   output logic signed [OUT_W-1:0] pcm_out,
   output logic                    pcm_vld
);
   localparam int unsigned SH_W = ACC_W - SHIFT;
   localparam logic signed [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

   logic signed [SH_W-1:0]  scaled;
   logic signed [OUT_W-1:0] limited;

   // Dropping the low bits of a two's complement value is a floor divide
   assign scaled = diff_i[ACC_W-1:SHIFT];

   if (SH_W > OUT_W && SATURATE) begin : g_clamp
      logic [SH_W-OUT_W:0] head;
      logic                in_range;
      assign head     = scaled[SH_W-1:OUT_W-1];
      assign in_range = (head == '0) || (head == '1);
      always_comb begin
         if (in_range) begin
            limited = scaled[OUT_W-1:0];
         end else if (scaled[SH_W-1]) begin
            limited = NEG_MAX;
         end else begin
            limited = POS_MAX;
         end
      end
   end else if (SH_W > OUT_W) begin : g_wrap
      assign limited = scaled[OUT_W-1:0];
   end else begin : g_extend
      assign limited = OUT_W'(scaled);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcm_out <= '0;
         pcm_vld <= 1'b0;
      end else if (clr) begin
         pcm_out <= '0;
         pcm_vld <= 1'b0;
      end else begin
         pcm_vld <= dump;
         if (dump) begin
            pcm_out <= limited;
         end
      end
   end

endmodule

// File: rtl/sdd_decimator.sv
module sdd_decimator #(
   parameter int unsigned DECIM    = sdd_pkg::SDD_DECIM,
   parameter int unsigned ORDER    = sdd_pkg::SDD_ORDER,
   parameter int unsigned OUT_W    = sdd_pkg::SDD_OUT_W,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             os_en,
   input  logic             bit_in,
   output logic [OUT_W-1:0] pcm_out,
   output logic             pcm_vld
);
   localparam int unsigned ACC_W     = sdd_pkg::acc_width(ORDER, DECIM);
   localparam int          SHIFT_RAW = sdd_pkg::scale_shift(ORDER, DECIM, OUT_W);
   localparam int unsigned SHIFT     = (SHIFT_RAW > 0) ? SHIFT_RAW : 0;

   // Elaboration-time parameter checks
   if (DECIM < 2 || (DECIM & (DECIM - 1)) != 0) begin : g_bad_decim
      $error("sdd_decimator: DECIM must be a power of two of at least 2");
   end
   if (ORDER < 1 || ORDER > 6) begin : g_bad_order
      $error("sdd_decimator: ORDER must be between 1 and 6");
   end
   if (OUT_W < 2 || OUT_W > ACC_W) begin : g_bad_outw
      $error("sdd_decimator: OUT_W must lie between 2 and the accumulator width");
   end
   if (SHIFT_RAW < 0) begin : g_bad_shift
      $error("sdd_decimator: filter gain too small for OUT_W");
   end

   logic                    dump;
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] diff;
   logic signed [OUT_W-1:0] word;

   sdd_phase_ctr #(
      .DECIM (DECIM)
   ) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .os_en (os_en),
      .dump  (dump)
   );

   sdd_integ_chain #(
      .ORDER (ORDER),
      .ACC_W (ACC_W)
   ) u_integ (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .os_en  (os_en),
      .bit_in (bit_in),
      .acc_o  (acc)
   );

   sdd_comb_chain #(
      .ORDER (ORDER),
      .ACC_W (ACC_W)
   ) u_comb (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .dump   (dump),
      .acc_i  (acc),
      .diff_o (diff)
   );

   sdd_scale_sat #(
      .ACC_W    (ACC_W),
      .OUT_W    (OUT_W),
      .SHIFT    (SHIFT),
      .SATURATE (SATURATE)
   ) u_scale (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .dump    (dump),
      .diff_i  (diff),
      .pcm_out (word),
      .pcm_vld (pcm_vld)
   );

   assign pcm_out = word;

endmodule

// File: rtl/sdd_decimator_chk.sv
module sdd_decimator_chk #(
   parameter int unsigned DECIM = 64,
   parameter int unsigned OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             os_en,
   input logic             bit_in,
   input logic [OUT_W-1:0] pcm_out,
   input logic             pcm_vld
);
   localparam int unsigned CW = (DECIM > 2) ? $clog2(DECIM) : 1;
   localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

   // Independent tally of accepted enables, restarted by clear
   logic [CW-1:0] seen_q;
   logic          hit_q;
   logic          due_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         hit_q  <= 1'b0;
         due_q  <= 1'b0;
      end else if (clr) begin
         seen_q <= '0;
         hit_q  <= 1'b0;
         due_q  <= 1'b0;
      end else begin
         if (os_en) seen_q <= seen_q + 1'b1;
         hit_q <= os_en && (seen_q == LAST);
         due_q <= hit_q;
      end
   end

   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (pcm_out == '0 && !pcm_vld)); // R1

   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_vld |=> !pcm_vld); // R2

   AST_VLD_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      due_q |-> pcm_vld); // R2

   AST_VLD_ONLY_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_vld |-> due_q); // R8

   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!pcm_vld && !$past(clr)) |-> $stable(pcm_out)); // R9

   // bit_in is an input of the bound block; kept for a complete port view
   logic unused_bit;
   assign unused_bit = bit_in;

endmodule

bind sdd_decimator sdd_decimator_chk #(
   .DECIM (DECIM),
   .OUT_W (OUT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr),
   .os_en   (os_en),
   .bit_in  (bit_in),
   .pcm_out (pcm_out),
   .pcm_vld (pcm_vld)
);

// File: tb/sim_sdd_decimator.sv
`timescale 1ns/1ps
module sim_sdd_decimator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        os_en = 1'b0;
   logic        bit_in = 1'b0;
   logic [15:0] pcm_out;
   logic        pcm_vld;

   int    n_vec  = 0;
   int    n_bad  = 0;
   int    cycles = 0;
   int    vld_seen = 0;
   string tag = "R1";
   bit    done = 1'b0;

   always #5 clk = ~clk;

   sdd_decimator u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .os_en   (os_en),
      .bit_in  (bit_in),
      .pcm_out (pcm_out),
      .pcm_vld (pcm_vld)
   );

   // Behavioural model: unbounded integers, no wraparound
   longint  m_i1, m_i2, m_i3, m_c1, m_c2, m_c3;
   int      m_cnt;
   bit      m_dump;
   logic [15:0] exp_out;
   bit      exp_vld;

   function automatic logic [15:0] to_pcm(input longint c);
      longint y;
      y = c >>> 3;
      if (y > 32767)  y = 32767;
      if (y < -32768) y = -32768;
      return 16'(y);
   endfunction

   task automatic model_clear();
      m_i1 = 0; m_i2 = 0; m_i3 = 0;
      m_c1 = 0; m_c2 = 0; m_c3 = 0;
      m_cnt = 0; m_dump = 0;
      exp_out = '0; exp_vld = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n || clr) begin
         model_clear();
      end else begin
         longint d1, d2, d3;
         bit     nxt;
         if (m_dump) begin
            d1 = m_i3 - m_c1;
            d2 = d1 - m_c2;
            d3 = d2 - m_c3;
            m_c1 = m_i3; m_c2 = d1; m_c3 = d2;
            exp_out = to_pcm(d3);
            exp_vld = 1;
         end else begin
            exp_vld = 0;
         end
         nxt = os_en && (m_cnt == 63);
         if (os_en) begin
            m_i3 = m_i3 + m_i2;
            m_i2 = m_i2 + m_i1;
            m_i1 = m_i1 + (bit_in ? 1 : -1);
            m_cnt = (m_cnt + 1) % 64;
         end
         m_dump = nxt;
      end
   end

   // Compare on every falling edge
   always @(negedge clk) begin
      cycles++;
      if (pcm_vld) vld_seen++;
      if (rst_n && !done) begin
         n_vec++;
         if (pcm_vld !== exp_vld || pcm_out !== exp_out) begin
            n_bad++;
            $display("FAIL %s: vld=%0b out=%h expected vld=%0b out=%h at cycle %0d",
                     tag, pcm_vld, pcm_out, exp_vld, exp_out, cycles);
         end
      end
      if (cycles > 150000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: cycles=%0d expected completion before 150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic check(input string t, input logic [15:0] act, input logic [15:0] expv);
      n_vec++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", t, act, expv);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         os_en = 0;
         bit_in = $urandom_range(0, 1);
      end
   endtask

   // Feed n accepted bits; pattern 0 ones, 1 zeros, 2 alternating, 3 random
   task automatic feed(input int n, input int pat, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         os_en = 1;
         case (pat)
            0: bit_in = 1;
            1: bit_in = 0;
            2: bit_in = i[0];
            default: bit_in = $urandom_range(0, 1);
         endcase
         if (gap > 0) idle(gap);
         else if (gap < 0) idle($urandom_range(0, 3));
      end
      @(negedge clk);
      os_en = 0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      os_en = 0;
      clr = 1;
      @(negedge clk);
      clr = 0;
      check("R1 clear out", pcm_out, 16'h0000);
      check("R1 clear vld", {15'd0, pcm_vld}, 16'h0000);
   endtask

   initial begin
      model_clear();
      repeat (4) @(negedge clk);
      check("R1 reset out", pcm_out, 16'h0000);
      check("R1 reset vld", {15'd0, pcm_vld}, 16'h0000);
      rst_n = 1;
      idle(3);

      tag = "R5 R4 all ones, back to back";
      feed(64 * 6, 0, 0);
      idle(4);
      check("R5 settled ones", pcm_out, 16'h7FFF);

      do_clear();
      tag = "R6 R10 all zeros, every other cycle";
      feed(64 * 6, 1, 1);
      idle(4);
      check("R6 settled zeros", pcm_out, 16'h8000);

      do_clear();
      tag = "R7 alternating bits";
      feed(64 * 5, 2, 0);
      idle(4);

      do_clear();
      tag = "R3 R4 R7 R10 random bits, irregular enables";
      feed(64 * 12, 3, -1);
      idle(4);

      tag = "R4 ones after random";
      feed(64 * 2, 0, 2);
      idle(4);
      n_vec++;
      if ($signed(pcm_out) <= 0) begin
         n_bad++;
         $display("FAIL R4: actual=%h expected a positive word", pcm_out);
      end

      // R8 and R2: clear in mid-window, then count strobes
      tag = "R8 clear mid-window";
      feed(30, 3, 0);
      do_clear();
      vld_seen = 0;
      feed(63, 3, 0);
      idle(4);
      check("R8 no strobe before 64th enable", 16'(vld_seen), 16'd0);
      feed(1, 3, 0);
      idle(4);
      check("R2 one strobe after 64th enable", 16'(vld_seen), 16'd1);
      tag = "R2 strobe count";
      vld_seen = 0;
      feed(64 * 4, 3, -1);
      idle(4);
      check("R2 strobes per 256 enables", 16'(vld_seen), 16'd4);

      tag = "R9 hold while idle";
      begin
         logic [15:0] held;
         held = pcm_out;
         idle(40);
         check("R9 output held", pcm_out, held);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule